// File: doc/BRIEF.md
# Dual-Channel PWM Generator with Posted Register Updates

This block produces pulse-width-modulated outputs on two independent channels. Each channel counts input clocks through a prescaler and a period counter. Its output is driven active while the period count is below a duty threshold. Software programs each channel through four word registers on a simple synchronous read/write port: control, prescale, period and duty.

Writes are posted. A written value lands at once in a shadow copy, which is what reads return. It then travels through a two-flop synchronizer and one transfer cycle before it reaches the running configuration. For every register a pending flag in a shared status word shows whether that journey is still under way, so software can poll the flag before it issues the next write to the same register. Period and duty values can be held back until the next period boundary (autoload) to avoid glitched pulses.

Stopping can be abrupt or graceful. With the stop-at-once bit set, the output falls to its idle level as soon as the disable takes effect. Without it, the current period runs to its end first.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After reset all shadow and active registers, all pending flags and both counters are zero, and both outputs are low.
- R2: Channel n (n = 0 or 1) sits at byte address 16*n, with control at +0, prescale at +4, period at +8 and duty at +12. The status word sits at 0x40. Reads return the shadow value, zero-extended and masked to 6, 10, 12 and 12 bits for the four registers. Writes to the status word, to the window of channels 2 and 3, or to a misaligned address change nothing, and those addresses read 0.
- R3: Status bit 8*n+k is the pending flag of channel n, register k, where k is 0 for control, 1 for prescale, 2 for period and 3 for duty. All other status bits read 0.
- R4: A write accepted at clock edge T sets its pending flag from edge T. The value reaches the active configuration at edge T+2. The flag clears at edge T+2, unless a later write to the same register is still in flight.
- R5: While running, one output period lasts (prescale+1)*(period+1) clocks. The output is active during the first (prescale+1)*duty clocks of each period.
- R6: A duty value greater than or equal to the period value keeps the output active for the whole period.
- R7: Control bit 2 (autoload) makes newly transferred period and duty values wait for the next period wrap. When the bit is clear, they take effect at the transfer edge.
- R8: Control bit 0 enables the channel, and counting starts from zero one cycle after the enable becomes active. Control bit 1 inverts the output, so the idle level is low, or high when the bit is set.
- R9: With control bit 0 clear and bit 3 (stop at once) set, the output takes its idle level in the same cycle that control value becomes active. With bit 3 clear, the current period finishes first.
- R10: Control bit 4 restarts both counters when a prescale value transfers. Control bit 5 restarts both counters when a period value takes effect without autoload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the register port and the counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 7 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational from the shadow and status state |
| pwm_out | output | 2 | One PWM output per channel |

## Verification
A wrong active configuration shows on pwm_out within one output period. A wrong counter or run state shows in the next clock, because the output is compared against an independent model on every cycle. A pending flag that is stuck, or that clears too early, is caught by status reads on the write edge and on the two edges after it. A transfer that lands one cycle early or late moves the output's edges relative to the model, and the mismatch is reported on that same cycle. A missed restart or autoload shows as an output edge that appears before or after the expected period wrap.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

  // Control word, bit 0 first from the bottom: en, inv, autoload, stop, ld_pre, ld_per
  typedef struct packed {
    logic ld_per;
    logic ld_pre;
    logic stop;
    logic autoload;
    logic inv;
    logic en;
  } pwm_ctrl_t;

  localparam int CTRL_W    = 6;
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_PRE  = 1;
  localparam int SLOT_PER  = 2;
  localparam int SLOT_DUTY = 3;
  localparam int NUM_SLOTS = 4;

  // Output drive for a given count; duty at or above period means always on
  function automatic logic drive_active(input logic [31:0] cnt,
                                        input logic [31:0] duty,
                                        input logic [31:0] per);
    return (duty >= per) || (cnt < duty);
  endfunction

endpackage

// File: rtl/pwm_xfer_sync.sv
module pwm_xfer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  output logic pending,
  output logic xfer
);
  logic [STAGES-1:0] stg;
  logic              older_in_flight;

  assign xfer            = stg[STAGES-1];
  assign older_in_flight = |stg[STAGES-2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg     <= '0;
      pending <= 1'b0;
    end else begin
      stg <= {stg[STAGES-2:0], wr};
      if (wr)
        pending <= 1'b1;
      else if (xfer && !older_in_flight)
        pending <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
  import pwm_shadow_pkg::*;
#(
  parameter int PRE_W = 10,
  parameter int PER_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pwm_ctrl_t            sh_ctrl,
  input  logic [PRE_W-1:0]     sh_pre,
  input  logic [PER_W-1:0]     sh_per,
  input  logic [PER_W-1:0]     sh_duty,
  input  logic [NUM_SLOTS-1:0] xfer,
  output logic                 pwm,
  output logic                 run,
  output logic                 halt,
  output logic                 wrap
);
  pwm_ctrl_t        act_ctrl;
  logic [PRE_W-1:0] act_pre, pc;
  logic [PER_W-1:0] act_per, act_duty, arm_per, arm_duty, cnt;
  logic             per_armed, duty_armed, running;
  logic             tick, at_end, restart;

  assign halt    = !act_ctrl.en && act_ctrl.stop;
  assign tick    = pc >= act_pre;
  assign at_end  = cnt >= act_per;
  assign restart = (xfer[SLOT_PRE] && act_ctrl.ld_pre) ||
                   (xfer[SLOT_PER] && !act_ctrl.autoload && act_ctrl.ld_per);
  assign wrap    = running && !halt && !restart && tick && at_end;
  assign run     = running;
  assign pwm     = act_ctrl.inv ^
                   (running && !halt && drive_active(32'(cnt), 32'(act_duty), 32'(act_per)));

  // Active configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ctrl   <= '0;
      act_pre    <= '0;
      act_per    <= '0;
      act_duty   <= '0;
      arm_per    <= '0;
      arm_duty   <= '0;
      per_armed  <= 1'b0;
      duty_armed <= 1'b0;
    end else begin
      if (xfer[SLOT_CTRL]) act_ctrl <= sh_ctrl;
      if (xfer[SLOT_PRE])  act_pre  <= sh_pre;
      if (wrap && per_armed) begin
        act_per   <= arm_per;
        per_armed <= 1'b0;
      end
      if (xfer[SLOT_PER]) begin
        if (act_ctrl.autoload) begin
          arm_per   <= sh_per;
          per_armed <= 1'b1;
        end else begin
          act_per   <= sh_per;
          per_armed <= 1'b0;
        end
      end
      if (wrap && duty_armed) begin
        act_duty   <= arm_duty;
        duty_armed <= 1'b0;
      end
      if (xfer[SLOT_DUTY]) begin
        if (act_ctrl.autoload) begin
          arm_duty   <= sh_duty;
          duty_armed <= 1'b1;
        end else begin
          act_duty   <= sh_duty;
          duty_armed <= 1'b0;
        end
      end
    end
  end

  // Prescaler, period counter and run state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pc      <= '0;
      cnt     <= '0;
    end else if (!running) begin
      pc  <= '0;
      cnt <= '0;
      if (act_ctrl.en) running <= 1'b1;
    end else if (halt) begin
      running <= 1'b0;
      pc      <= '0;
      cnt     <= '0;
    end else if (restart) begin
      pc  <= '0;
      cnt <= '0;
    end else if (tick) begin
      pc <= '0;
      if (at_end) begin
        cnt <= '0;
        if (!act_ctrl.en) running <= 1'b0;
      end else begin
        cnt <= cnt + PER_W'(1);
      end
    end else begin
      pc <= pc + PRE_W'(1);
    end
  end
endmodule

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
  import pwm_shadow_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int CH_SLOTS    = 4,
  parameter int PRE_W       = 10,
  parameter int PER_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int WIN_SHIFT   = 4;
  localparam int CH_BITS     = $clog2(CH_SLOTS);
  localparam int STATUS_ADDR = CH_SLOTS << WIN_SHIFT;
  localparam int PEND_BITS   = NUM_CH * NUM_SLOTS;

  logic               aligned, is_chan, is_status;
  logic [CH_BITS-1:0] ch_idx;
  logic [1:0]         slot_idx;
  logic               unused_wdata_hi;

  logic [PEND_BITS-1:0] wr_vec, pend_vec, xfer_vec;
  logic [NUM_CH-1:0]    run_vec, halt_vec, wrap_vec;
  logic [DATA_W-1:0]    status_word;

  pwm_ctrl_t        sh_ctrl [NUM_CH];
  logic [PRE_W-1:0] sh_pre  [NUM_CH];
  logic [PER_W-1:0] sh_per  [NUM_CH];
  logic [PER_W-1:0] sh_duty [NUM_CH];

  assign aligned         = bus_addr[1:0] == 2'b00;
  assign is_chan         = aligned && (bus_addr[ADDR_W-1:WIN_SHIFT+CH_BITS] == '0);
  assign is_status       = aligned && (bus_addr == ADDR_W'(STATUS_ADDR));
  assign ch_idx          = bus_addr[WIN_SHIFT+CH_BITS-1:WIN_SHIFT];
  assign slot_idx        = bus_addr[3:2];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:PER_W];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign wr_vec[c*NUM_SLOTS+s] = bus_we && is_chan &&
                                     (ch_idx == CH_BITS'(c)) && (slot_idx == 2'(s));
      pwm_xfer_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_vec[c*NUM_SLOTS+s]),
        .pending (pend_vec[c*NUM_SLOTS+s]),
        .xfer    (xfer_vec[c*NUM_SLOTS+s])
      );
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_ctrl[c] <= '0;
        sh_pre[c]  <= '0;
        sh_per[c]  <= '0;
        sh_duty[c] <= '0;
      end else begin
        if (wr_vec[c*NUM_SLOTS+SLOT_CTRL]) sh_ctrl[c] <= pwm_ctrl_t'(bus_wdata[CTRL_W-1:0]);
        if (wr_vec[c*NUM_SLOTS+SLOT_PRE])  sh_pre[c]  <= bus_wdata[PRE_W-1:0];
        if (wr_vec[c*NUM_SLOTS+SLOT_PER])  sh_per[c]  <= bus_wdata[PER_W-1:0];
        if (wr_vec[c*NUM_SLOTS+SLOT_DUTY]) sh_duty[c] <= bus_wdata[PER_W-1:0];
      end
    end

    pwm_chan_core #(.PRE_W(PRE_W), .PER_W(PER_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .sh_ctrl (sh_ctrl[c]),
      .sh_pre  (sh_pre[c]),
      .sh_per  (sh_per[c]),
      .sh_duty (sh_duty[c]),
      .xfer    (xfer_vec[c*NUM_SLOTS +: NUM_SLOTS]),
      .pwm     (pwm_out[c]),
      .run     (run_vec[c]),
      .halt    (halt_vec[c]),
      .wrap    (wrap_vec[c])
    );
  end

  // One status byte per channel, pending flags in its low nibble
  always_comb begin
    status_word = '0;
    for (int c = 0; c < NUM_CH; c++)
      status_word[c*8 +: NUM_SLOTS] = pend_vec[c*NUM_SLOTS +: NUM_SLOTS];
  end

  always_comb begin
    bus_rdata = '0;
    if (is_status) begin
      bus_rdata = status_word;
    end else if (is_chan) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_idx == CH_BITS'(c)) begin
          case (slot_idx)
            2'd0:    bus_rdata = DATA_W'(sh_ctrl[c]);
            2'd1:    bus_rdata = DATA_W'(sh_pre[c]);
            2'd2:    bus_rdata = DATA_W'(sh_per[c]);
            default: bus_rdata = DATA_W'(sh_duty[c]);
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pwm_shadow_chk.sv
module pwm_shadow_chk #(
  parameter int NUM_CH    = 2,
  parameter int PEND_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [PEND_BITS-1:0] wr_vec,
  input logic [PEND_BITS-1:0] pend_vec,
  input logic [PEND_BITS-1:0] xfer_vec,
  input logic [NUM_CH-1:0]    run_vec,
  input logic [NUM_CH-1:0]    halt_vec,
  input logic [NUM_CH-1:0]    wrap_vec
);
  for (genvar k = 0; k < PEND_BITS; k++) begin : g_pend
    // R4: an accepted write raises its pending flag on the next cycle
    p_pend_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_vec[k] |=> pend_vec[k]);
    // R4: a pending flag only drops on a transfer edge
    p_pend_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_vec[k]) |-> $past(xfer_vec[k]));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_run
    // R9: a stop-at-once request leaves the channel idle on the next cycle
    p_halt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halt_vec[c] |=> !run_vec[c]);
    // R9: running ends only at a period wrap or through stop-at-once
    p_stop_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_vec[c]) |-> ($past(wrap_vec[c]) || $past(halt_vec[c])));
  end
endmodule

bind pwm_shadow_ctrl pwm_shadow_chk #(.NUM_CH(NUM_CH), .PEND_BITS(PEND_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_vec   (wr_vec),
  .pend_vec (pend_vec),
  .xfer_vec (xfer_vec),
  .run_vec  (run_vec),
  .halt_vec (halt_vec),
  .wrap_vec (wrap_vec)
);

// File: tb/sim_pwm_shadow_ctrl.sv
module sim_pwm_shadow_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire  [1:0]  pwm_out;

  always #4 clk = ~clk;

  pwm_shadow_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    done = 0;

  // ---------------- behavioural reference model ----------------
  int m_sh[8];
  int m_ctrl[2], m_pre[2], m_per[2], m_duty[2], m_aper[2], m_aduty[2];
  int m_pc[2], m_cnt[2];
  bit m_pa[2], m_da[2], m_run[2];
  int xq[8][$];   // transfer edge numbers per register
  int cyc = 0;

  function automatic int slot_mask(int s);
    case (s)
      0: return 'h3F;
      1: return 'h3FF;
      default: return 'hFFF;
    endcase
  endfunction

  function automatic bit m_out(int c);
    bit halt_now, act;
    halt_now = !m_ctrl[c][0] && m_ctrl[c][3];
    act = m_run[c] && !halt_now && (m_duty[c] >= m_per[c] || m_cnt[c] < m_duty[c]);
    return m_ctrl[c][1] ^ act;
  endfunction

  function automatic int m_status();
    int v = 0;
    for (int i = 0; i < 8; i++) if (xq[i].size() > 0) v |= 1 << ((i / 4) * 8 + i % 4);
    return v;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_sh[i] = 0; xq[i].delete(); end
      for (int c = 0; c < 2; c++) begin
        m_ctrl[c] = 0; m_pre[c] = 0; m_per[c] = 0; m_duty[c] = 0;
        m_aper[c] = 0; m_aduty[c] = 0; m_pc[c] = 0; m_cnt[c] = 0;
        m_pa[c] = 0; m_da[c] = 0; m_run[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit xf[4];
        bit en, al, hlt, rs, tk, we_, wp;
        for (int s = 0; s < 4; s++) begin
          xf[s] = 0;
          if (xq[c*4+s].size() > 0 && xq[c*4+s][0] == cyc) begin
            xf[s] = 1;
            void'(xq[c*4+s].pop_front());
          end
        end
        en  = m_ctrl[c][0];
        al  = m_ctrl[c][2];
        hlt = !en && m_ctrl[c][3];
        rs  = (xf[1] && m_ctrl[c][4]) || (xf[2] && !al && m_ctrl[c][5]);
        tk  = m_pc[c] >= m_pre[c];
        we_ = m_cnt[c] >= m_per[c];
        wp  = m_run[c] && !hlt && !rs && tk && we_;
        if (!m_run[c]) begin
          m_pc[c] = 0; m_cnt[c] = 0; m_run[c] = en;
        end else if (hlt) begin
          m_run[c] = 0; m_pc[c] = 0; m_cnt[c] = 0;
        end else if (rs) begin
          m_pc[c] = 0; m_cnt[c] = 0;
        end else if (tk) begin
          m_pc[c] = 0;
          if (we_) begin m_cnt[c] = 0; if (!en) m_run[c] = 0; end
          else m_cnt[c] = m_cnt[c] + 1;
        end else begin
          m_pc[c] = m_pc[c] + 1;
        end
        if (xf[0]) m_ctrl[c] = m_sh[c*4+0];
        if (xf[1]) m_pre[c]  = m_sh[c*4+1];
        if (wp && m_pa[c]) begin m_per[c] = m_aper[c]; m_pa[c] = 0; end
        if (xf[2]) begin
          if (al) begin m_aper[c] = m_sh[c*4+2]; m_pa[c] = 1; end
          else begin m_per[c] = m_sh[c*4+2]; m_pa[c] = 0; end
        end
        if (wp && m_da[c]) begin m_duty[c] = m_aduty[c]; m_da[c] = 0; end
        if (xf[3]) begin
          if (al) begin m_aduty[c] = m_sh[c*4+3]; m_da[c] = 1; end
          else begin m_duty[c] = m_sh[c*4+3]; m_da[c] = 0; end
        end
      end
      if (bus_we && bus_addr < 7'h40 && bus_addr[5:4] < 2'd2 && bus_addr[1:0] == 2'b00) begin
        int idx;
        idx = int'(bus_addr[5:4]) * 4 + int'(bus_addr[3:2]);
        m_sh[idx] = int'(bus_wdata) & slot_mask(idx % 4);
        xq[idx].push_back(cyc + 2);
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done)
      for (int c = 0; c < 2; c++) check(tag, "pwm_out vs model", int'(pwm_out[c]), int'(m_out(c)));
  end

  task automatic wr(input int a, input int d);
    bus_addr = 7'(a); bus_wdata = 32'(d); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = 7'(a);
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int c, input int n, output int h);
    h = 0;
    repeat (n) begin @(negedge clk); h += int'(pwm_out[c]); end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    tag = "R1";
    check("R1", "pwm_out", int'(pwm_out), 0);
    rd('h40, v); check("R1", "status", v, 0);
    rd('h08, v); check("R1", "period0", v, 0);

    // R4 / R3 pending latency on prescale of channel 0
    tag = "R4";
    wr('h04, 1);
    rd('h40, v); check("R4", "pend at T", v, 'h2);
    check("R3", "status vs model", v, m_status());
    idle(1); rd('h40, v); check("R4", "pend at T+1", v, 'h2);
    idle(1); rd('h40, v); check("R4", "pend at T+2", v, 0);

    // R2 readback and masking
    tag = "R2";
    wr('h04, 'hFFFF);
    idle(3); rd('h04, v); check("R2", "prescale masked", v, 'h3FF);
    wr('h04, 1); wr('h08, 4); wr('h0C, 2);
    idle(3); rd('h08, v); check("R2", "period0", v, 4);
    rd('h0C, v); check("R2", "duty0", v, 2);

    // R3 channel 1 status byte
    tag = "R3";
    wr('h1C, 5);
    rd('h40, v); check("R3", "ch1 duty pending bit 11", v, 'h800);
    idle(3);

    // R5 / R8 basic waveform
    tag = "R5";
    wr('h00, 1); idle(10);
    count_high(0, 40, h); check("R5", "high cycles pre1 per4 duty2", h, 16);

    // R6 duty at and above period
    tag = "R6";
    wr('h0C, 4); idle(5);
    count_high(0, 20, h); check("R6", "duty==period", h, 20);
    wr('h0C, 7); idle(5);
    count_high(0, 20, h); check("R6", "duty>period", h, 20);
    tag = "R5";
    wr('h0C, 0); idle(5);
    count_high(0, 20, h); check("R5", "duty zero", h, 0);

    // R7 autoload
    tag = "R7";
    wr('h00, 'h5); idle(3);
    wr('h0C, 2); wr('h08, 9); idle(30);
    count_high(0, 40, h); check("R7", "autoload per9 duty2", h, 8);

    // R8 inversion
    tag = "R8";
    wr('h00, 'h7); idle(5);
    count_high(0, 40, h); check("R8", "inverted high cycles", h, 32);

    // R9 graceful stop with invert: idle level high
    tag = "R9";
    wr('h00, 'h6); idle(30);
    check("R9", "idle level inverted", int'(pwm_out[0]), 1);

    // R9 stop at once
    wr('h00, 'h1); wr('h0C, 15); idle(25);
    check("R6", "always active", int'(pwm_out[0]), 1);
    wr('h00, 'h8);
    check("R9", "still active at T", int'(pwm_out[0]), 1);
    idle(1); check("R9", "still active at T+1", int'(pwm_out[0]), 1);
    idle(1); check("R9", "idle at T+2", int'(pwm_out[0]), 0);
    wr('h00, 'h1); idle(25);
    check("R8", "re-enabled", int'(pwm_out[0]), 1);
    wr('h00, 'h0); idle(25);
    check("R9", "idle after period end", int'(pwm_out[0]), 0);

    // R10 counter restart on period transfer
    tag = "R10";
    wr('h00, 'h31); wr('h0C, 3); idle(25);
    for (int i = 0; i < 3; i++) begin
      wr('h08, 9); idle(2);
      check("R10", "active right after restart", int'(pwm_out[0]), 1);
      idle(5);
    end

    // R2 unimplemented and read-only addresses
    tag = "R2";
    idle(3);
    wr('h20, 'hFF); rd('h20, v); check("R2", "ch2 window reads zero", v, 0);
    rd('h40, v); check("R2", "ch2 write no pending", v, 0);
    wr('h40, 'hFF); rd('h40, v); check("R2", "status not writable", v, 0);
    wr('h0D, 'hFF); idle(3); rd('h0C, v); check("R2", "misaligned ignored", v, 3);

    // R5 channel 1 independent
    tag = "R5";
    wr('h14, 0); wr('h18, 3); wr('h1C, 1); wr('h10, 1); idle(10);
    count_high(1, 40, h); check("R5", "ch1 per3 duty1", h, 10);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule